// File: doc/BRIEF.md
# Keyed Configuration Word Loader

This block runs once after each start pulse. It walks a non-volatile word store and decodes keyed configuration records. The store is read through a request/response word port. Each record is two 32-bit words: a key and the data that follows it. A key word carries a fixed marker byte in its low byte and names a target register offset in its upper half. The data word after a key is sent out on a write strobe together with that offset.

Two offsets are special: the station-address low word and the station-address high word. When the data for either one arrives, the block keeps a copy, and from the two copies it builds a 48-bit MAC address. The scan stops at the first word in key position that lacks the marker, at a read error, or when a word-count limit is reached. On stopping, the block raises a one-cycle done pulse. It also raises a validity flag, which stays as it is until the next start.

The read port has two channels that follow valid/ready rules. On the request channel, once `rd_req_valid_o` is high, it stays high and `rd_req_addr_o` does not change until `rd_req_ready_i` is seen high at a clock edge. At most one read is outstanding at a time. On the response channel, the loader raises `rd_rsp_ready_o` only while it waits for a response. The memory side may hold `rd_rsp_valid_i` low for any number of cycles. Control and status pins are plain levels and pulses.

Top module: `kcl_loader`

## Requirements
- R1: A start pulse while idle begins a scan. The first read is at 0x100 when `src_sel_i`=0 and at 0x1F000 when `src_sel_i`=1. Each later read is 4 bytes above the one before it.
- R2: A word read in key position is a key when its bits 7:0 equal 0x5A. Its bits 31:16 become the target offset.
- R3: The word read after a key is data. One cycle after that data word is accepted, `wr_strobe_o` pulses for one cycle, with `wr_offset_o` set to the key's target and `wr_data_o` set to the data word. The loader then expects a key again, so a data word whose low byte is 0x5A is still treated as data.
- R4: The scan ends on either of two words: a key-position word without the marker, or a response that has `rd_rsp_err_i` set. The loader accepts that word but does not apply it.
- R5: Data sent to offset STA_OFFSET (default 0x0148) is kept as the low station word. Data sent to STA_OFFSET+4 is kept as the high station word. Data sent to any other offset does not affect the MAC address.
- R6: `mac_addr_o[47:32]` is bits 15:0 of the high station word. `mac_addr_o[31:0]` is the low station word. So the low word's top byte becomes address byte 2, and high-word bits 15:8 become byte 0, the most significant byte.
- R7: `mac_valid_o` is high only when a scan has finished, the address is not all zeros, and `mac_addr_o[40]` (the multicast bit of byte 0) is 0.
- R8: Both station words are reset to zero when each scan starts, so values from an earlier scan never carry over.
- R9: A scan reads at most MAX_WORDS words. After the last word allowed by that limit is accepted, the scan ends and that word is still applied.
- R10: After reset, all outputs are low. Once per scan, `done_o` is high for exactly one cycle, and that cycle comes right after the last word is accepted. `mac_valid_o` and `mac_addr_o` hold their values until the next start.
- R11: A read request holds its valid signal and address until it is accepted, and only one read is outstanding at a time.
- R12: A start pulse during a scan is ignored. The scan goes on from its original base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan |
| src_sel_i | input | 1 | Store select: 0 = low base, 1 = high base |
| busy_o | output | 1 | Scan in progress |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | ADDR_W | Byte address of the word to read |
| rd_rsp_valid_i | input | 1 | Response word present |
| rd_rsp_ready_o | output | 1 | Loader waits for a response |
| rd_rsp_data_i | input | 32 | Response word |
| rd_rsp_err_i | input | 1 | Response is a read failure |
| wr_strobe_o | output | 1 | Apply one keyed write |
| wr_offset_o | output | 16 | Target offset of the write |
| wr_data_o | output | 32 | Data of the write |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| mac_valid_o | output | 1 | Assembled address is usable |
| mac_addr_o | output | 48 | Assembled address, byte 0 in bits 47:40 |

## Verification
The bench builds the loader with MAX_WORDS=8 and the default STA_OFFSET. With this small limit, a store image full of records reaches the runaway limit in only a few reads. The sweep runs eight store images, each through both base addresses and three memory-latency and back-pressure settings. Together these cover every way a scan can end, the case where the error lands on a data word, the multicast and all-zero results, and a start pulse sent in the middle of a scan.

// File: rtl/kcl_pkg.sv
package kcl_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_FIN
  } kcl_state_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 16;
  localparam int unsigned MAC_W  = 48;
  localparam logic [7:0]  KEY_MARK = 8'h5A;
endpackage

// File: rtl/kcl_seq.sv
module kcl_seq
  import kcl_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned MAX_WORDS = 64,
  parameter logic [ADDR_W-1:0] BASE_LO = 'h100,
  parameter logic [ADDR_W-1:0] BASE_HI = 'h1F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              src_sel_i,
  input  logic              stop_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  output logic              fire_o,
  output logic              clear_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              have_result_o
);
  localparam int unsigned CNT_W = $clog2(MAX_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_WORDS - 1);

  kcl_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              res_q;
  logic              idle_like, start_ok, last, finish;

  assign idle_like = (state_q == S_IDLE) || (state_q == S_FIN);
  assign start_ok  = start_i && idle_like;
  assign fire_o    = rsp_valid_i && (state_q == S_WAIT);
  assign last      = (cnt_q == LAST_CNT);
  assign finish    = fire_o && (stop_i || last);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (start_ok) state_d = S_REQ;
      S_FIN:   state_d = start_ok ? S_REQ : S_IDLE;
      S_REQ:   if (req_ready_i) state_d = S_WAIT;
      S_WAIT:  if (fire_o) state_d = finish ? S_FIN : S_REQ;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      res_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        addr_q <= src_sel_i ? BASE_HI : BASE_LO;
        cnt_q  <= '0;
        res_q  <= 1'b0;
      end else if (fire_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (finish) res_q <= 1'b1;
        else        addr_q <= addr_q + ADDR_W'(4);
      end
    end
  end

  assign req_valid_o   = (state_q == S_REQ);
  assign req_addr_o    = addr_q;
  assign rsp_ready_o   = (state_q == S_WAIT);
  assign clear_o       = start_ok;
  assign done_o        = (state_q == S_FIN);
  assign busy_o        = (state_q == S_REQ) || (state_q == S_WAIT);
  assign have_result_o = res_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rsp_valid_i && rsp_ready_o));

  // R9
  word_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_WORDS));
endmodule

// File: rtl/kcl_parse.sv
module kcl_parse
  import kcl_pkg::*;
#(
  parameter logic [OFS_W-1:0] STA_OFFSET = 16'h0148
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              fire_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              err_i,
  output logic              stop_o,
  output logic              strobe_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] lo_o,
  output logic [WORD_W-1:0] hi_o
);
  localparam logic [OFS_W-1:0] STA_OFFSET_HI = STA_OFFSET + OFS_W'(4);

  logic             want_data_q;
  logic [OFS_W-1:0] tgt_q;
  logic             is_key, take_key, take_data;

  assign is_key    = (word_i[7:0] == KEY_MARK);
  assign take_key  = fire_i && !err_i && !want_data_q && is_key;
  assign take_data = fire_i && !err_i && want_data_q;
  assign stop_o    = fire_i && (err_i || (!want_data_q && !is_key));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_data_q <= 1'b0;
      tgt_q       <= '0;
      strobe_o    <= 1'b0;
      offset_o    <= '0;
      data_o      <= '0;
      lo_o        <= '0;
      hi_o        <= '0;
    end else begin
      strobe_o <= take_data;
      if (clear_i) begin
        want_data_q <= 1'b0;
        lo_o        <= '0;
        hi_o        <= '0;
      end else if (take_key) begin
        want_data_q <= 1'b1;
        tgt_q       <= word_i[31:16];
      end else if (take_data) begin
        want_data_q <= 1'b0;
        offset_o    <= tgt_q;
        data_o      <= word_i;
        if (tgt_q == STA_OFFSET)    lo_o <= word_i;
        if (tgt_q == STA_OFFSET_HI) hi_o <= word_i;
      end
    end
  end

  // R3
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/kcl_macfmt.sv
module kcl_macfmt
  import kcl_pkg::*;
(
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  output logic [MAC_W-1:0]  mac_o,
  output logic              ok_o
);
  localparam int unsigned NBYTES = MAC_W / 8;

  logic [NBYTES-1:0] nz;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    if (k < 4) begin : g_lo
      assign mac_o[8*k +: 8] = lo_i[8*k +: 8];
    end else begin : g_hi
      assign mac_o[8*k +: 8] = hi_i[8*(k-4) +: 8];
    end
    assign nz[k] = |mac_o[8*k +: 8];
  end

  assign ok_o = (|nz) && !mac_o[MAC_W-8];
endmodule

// File: rtl/kcl_loader.sv
module kcl_loader
  import kcl_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned MAX_WORDS = 64,
  parameter logic [ADDR_W-1:0] BASE_LO = 'h100,
  parameter logic [ADDR_W-1:0] BASE_HI = 'h1F000,
  parameter logic [15:0] STA_OFFSET = 16'h0148
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              src_sel_i,
  output logic              busy_o,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [31:0]       rd_rsp_data_i,
  input  logic              rd_rsp_err_i,
  output logic              wr_strobe_o,
  output logic [15:0]       wr_offset_o,
  output logic [31:0]       wr_data_o,
  output logic              done_o,
  output logic              mac_valid_o,
  output logic [47:0]       mac_addr_o
);
  logic fire, clear, stop, have_result, ok;
  logic [WORD_W-1:0] lo, hi;

  kcl_seq #(
    .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_sel_i(src_sel_i),
    .stop_i(stop), .req_valid_o(rd_req_valid_o), .req_ready_i(rd_req_ready_i),
    .req_addr_o(rd_req_addr_o), .rsp_valid_i(rd_rsp_valid_i),
    .rsp_ready_o(rd_rsp_ready_o), .fire_o(fire), .clear_o(clear),
    .done_o(done_o), .busy_o(busy_o), .have_result_o(have_result)
  );

  kcl_parse #(.STA_OFFSET(STA_OFFSET)) i_parse (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .fire_i(fire),
    .word_i(rd_rsp_data_i), .err_i(rd_rsp_err_i), .stop_o(stop),
    .strobe_o(wr_strobe_o), .offset_o(wr_offset_o), .data_o(wr_data_o),
    .lo_o(lo), .hi_o(hi)
  );

  kcl_macfmt i_fmt (.lo_i(lo), .hi_i(hi), .mac_o(mac_addr_o), .ok_o(ok));

  assign mac_valid_o = have_result && ok;
endmodule

// File: tb/test_kcl_loader.sv
module test_kcl_loader;
  localparam int MAXW = 8;
  localparam logic [15:0] STA = 16'h0148;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, src_sel_i = 1'b0;
  logic busy_o, rd_req_valid_o, rd_req_ready_i = 1'b0, rd_rsp_valid_i = 1'b0;
  logic rd_rsp_ready_o, rd_rsp_err_i = 1'b0, wr_strobe_o, done_o, mac_valid_o;
  logic [19:0] rd_req_addr_o;
  logic [31:0] rd_rsp_data_i = '0, wr_data_o;
  logic [15:0] wr_offset_o;
  logic [47:0] mac_addr_o;

  always #5 clk = ~clk;

  kcl_loader #(.MAX_WORDS(MAXW)) i_kcl_loader (.*);

  int n_tests = 0, n_fail = 0;
  logic [31:0] img [16];
  int err_idx, lat, base, ncyc;
  int n_issue, n_reads, n_str, n_done, addr_bad, str_bad;
  logic pend, rq_fire, rs_fire;
  int wt;
  logic [19:0] paddr;
  logic [47:0] got_mac;
  logic got_v;
  int e_reads, e_str;
  logic [31:0] e_lo, e_hi;
  logic [15:0] e_ofs [8];
  logic [31:0] e_dat [8];

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] key(input logic [15:0] t);
    return {t, 8'h00, 8'h5A};
  endfunction

  task automatic step();
    @(negedge clk);
    ncyc++;
    if (rq_fire) begin pend = 1; wt = lat; end
    if (rs_fire) begin rd_rsp_valid_i = 0; n_reads++; end
    if (wr_strobe_o) begin
      if (n_str < 8 && (wr_offset_o != e_ofs[n_str] || wr_data_o != e_dat[n_str])) str_bad++;
      n_str++;
    end
    if (done_o) begin n_done++; got_mac = mac_addr_o; got_v = mac_valid_o; end
    if (pend && !rd_rsp_valid_i) begin
      if (wt == 0) begin
        int idx;
        idx = (int'(paddr) - base) / 4;
        rd_rsp_valid_i = 1;
        rd_rsp_data_i = (idx >= 0 && idx < 16) ? img[idx] : 32'h0;
        rd_rsp_err_i = (idx == err_idx);
        pend = 0;
      end else wt--;
    end
    rd_req_ready_i = (lat == 0) ? 1'b1 : ncyc[0];
    rq_fire = rd_req_valid_o && rd_req_ready_i;
    if (rq_fire) begin
      paddr = rd_req_addr_o;
      if (int'(rd_req_addr_o) != base + 4 * n_issue) addr_bad++;
      n_issue++;
    end
    rs_fire = rd_rsp_valid_i && rd_rsp_ready_o;
  endtask

  task automatic set_image(input int n);
    for (int i = 0; i < 16; i++) img[i] = 32'h0;
    err_idx = -1;
    case (n)
      0: begin img[0] = key(STA); img[1] = 32'h6AF600DC; img[2] = key(STA + 4); img[3] = 32'h0000000B; end
      1: begin img[0] = key(STA); img[1] = 32'h6AF600DC; img[2] = key(STA + 4); img[3] = 32'h00000100; end
      2: begin img[0] = key(STA); img[1] = 32'h6AF600DC; img[2] = key(STA + 4); img[3] = 32'h0000000B; err_idx = 3; end
      3: begin img[0] = 32'h12345678; img[1] = 32'h6AF600DC; end
      4: begin img[0] = key(16'h0010); img[1] = 32'hDEAD005A; img[2] = key(STA); img[3] = 32'h11223344;
               img[4] = key(STA + 4); img[5] = 32'hFFFF0002; end
      5: for (int i = 0; i < 16; i++) img[i] = (i % 2 == 0) ? key(16'h0020) : 32'hA0000000 + i;
      6: begin img[0] = key(STA + 4); img[1] = 32'h00000200; end
      default: begin img[0] = key(STA + 8); img[1] = 32'h01020304; end
    endcase
  endtask

  // Expected behaviour from the requirements
  task automatic model();
    bit want_d = 0;
    logic [15:0] t = '0;
    e_reads = 0; e_str = 0; e_lo = '0; e_hi = '0;
    for (int i = 0; i < MAXW; i++) begin
      e_reads = i + 1;
      if (i == err_idx) break;
      if (!want_d) begin
        if (img[i][7:0] != 8'h5A) break;
        t = img[i][31:16]; want_d = 1;
      end else begin
        if (e_str < 8) begin e_ofs[e_str] = t; e_dat[e_str] = img[i]; end
        e_str++;
        if (t == STA) e_lo = img[i];
        else if (t == STA + 16'd4) e_hi = img[i];
        want_d = 0;
      end
    end
  endtask

  task automatic run_scan(input int sel, input int l, input bit dbl);
    logic [47:0] e_mac;
    logic e_v;
    int k;
    lat = l; base = sel ? 'h1F000 : 'h100;
    n_issue = 0; n_reads = 0; n_str = 0; n_done = 0; addr_bad = 0; str_bad = 0;
    model();
    e_mac = {e_hi[15:0], e_lo};
    e_v = (e_mac != 0) && !e_mac[40];
    src_sel_i = sel[0]; start_i = 1;
    step();
    start_i = 0;
    k = 0;
    while (n_done == 0 && k < 300) begin
      if (dbl && k == 2) begin start_i = 1; src_sel_i = ~sel[0]; end
      else start_i = 0;
      step(); k++;
    end
    start_i = 0;
    for (int i = 0; i < 3; i++) step();
    chk(addr_bad == 0, "R1 addresses", addr_bad, 0);
    chk(n_reads == e_reads, "R4/R9 words read", n_reads, e_reads);
    chk(n_str == e_str && str_bad == 0, "R2/R3 strobes", n_str, e_str);
    chk(n_done == 1, "R10 done pulses", n_done, 1);
    chk(got_mac == e_mac, "R5/R6/R8 mac", got_mac, e_mac);
    chk(got_v == e_v, "R7 valid", got_v, e_v);
    chk(mac_valid_o == e_v && mac_addr_o == e_mac, "R10 held", mac_addr_o, e_mac);
    if (dbl) chk(n_issue == e_reads, "R12 restart ignored", n_issue, e_reads);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    pend = 0; rq_fire = 0; rs_fire = 0; wt = 0; ncyc = 0; lat = 0; base = 0;
    err_idx = -1; paddr = '0; got_mac = '0; got_v = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk({busy_o, done_o, mac_valid_o, wr_strobe_o, rd_req_valid_o} == 0, "R10 reset", busy_o, 0);
    chk(mac_addr_o == 0, "R10 reset mac", mac_addr_o, 0);
    // R8: each image follows a different one, so stale station words would show
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 3; l++)
        for (int n = 0; n < 8; n++) begin
          set_image(n);
          run_scan(s, l, 1'b0);
        end
    // R12: start during a scan with the other store selected
    set_image(0);
    run_scan(0, 2, 1'b1);
    set_image(4);
    run_scan(1, 1, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule